// File: doc/BRIEF.md
# SPI Routed Parameter Frame Receiver

This block is a serial-peripheral slave that sits inside a board-level logic device. A host shifts 16-bit words into it while the block's own chip select is held low. The words arrive in pairs. The first word of a pair names the register that the following word is written to. A reserved end word, sent where the next address would go, closes the sequence. Each completed pair leaves the block as a one-cycle write strobe carrying a 16-bit address and 16-bit data. The end word produces a one-cycle completion pulse.

The serial clock is far slower than the system clock. The block therefore brings the chip select, serial clock and data line into the system clock domain through synchronizer stages, and it finds serial clock rising edges there. A host can check the link by reading back the data-out line: during each word it carries the previous complete word.

If the chip select is released part way through a word, or between an address word and its data word, the block discards the incomplete item and raises a sticky error flag. It then expects an address word again.

The pair decoder has two states. PS_ADDR waits for an address word. In that state, a word other than the end code is latched as the address and moves the decoder to PS_DATA. The end code produces the completion pulse and the decoder stays in PS_ADDR. PS_DATA waits for the data word. A word there produces the write strobe and returns the decoder to PS_ADDR. An abort in either state forces the decoder to PS_ADDR.

Top module: `spi_param_rx`

## Requirements
- R1: Words are 16 bits, taken most significant bit first, with one bit sampled on each rising serial clock edge (mode 0, idle clock low) while `spi_cs_n` is low.
- R2: While `spi_cs_n` is high, serial clock and data activity are ignored. Each new selection starts a fresh word at bit 0.
- R3: An address word followed by a data word produces exactly one `wr_en` pulse, one system clock long. During the pulse, `wr_addr` equals the first word and `wr_data` equals the second.
- R4: A word equal to END_CODE (default 16'hFFFF) in the address position produces a one-cycle `seq_done` pulse and no write. In the data position, the same value is ordinary data.
- R5: Releasing `spi_cs_n` after 1 to 15 bits of a word discards those bits without a write and sets `link_err`.
- R6: Releasing `spi_cs_n` after an address word but before its data word discards the address and sets `link_err`. The next word received is treated as an address.
- R7: `link_err` stays high through later writes and is cleared by the next `seq_done`.
- R8: During each word, `spi_miso` presents the previously completed word, most significant bit first, with each bit valid at the rising edge that samples the matching input bit. Before any word is complete, that echoed word is zero. `spi_miso` is low while deselected.
- R9: After reset, `wr_en`, `seq_done`, `link_err` and `spi_miso` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select for this slave |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial echo of previous word to host |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 16 | Register address of the write |
| wr_data | output | 16 | Data of the write |
| seq_done | output | 1 | One-cycle pulse on a received end code |
| link_err | output | 1 | Sticky flag for an aborted word or pair |

## Verification
The main function is tried with a single clean pair and with a multi-pair sequence closed by the end code. These cases show whether pairing and bit order are correct. The end-code value is also sent as data, which separates position-based end detection from value-based detection. Clock pulses sent while deselected check that no bits leak into the next word. Releases after seven bits and after a whole address word separate frame-level recovery from pair-level recovery. The echoed words, read back on the data-out line, show whether only complete words update the echo.

// File: rtl/prx_pkg.sv
`timescale 1ns/1ps
package prx_pkg;
    typedef enum logic [0:0] {
        PS_ADDR = 1'b0,
        PS_DATA = 1'b1
    } pair_state_t;
endpackage

// File: rtl/prx_sync.sv
`timescale 1ns/1ps
module prx_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/prx_shifter.sv
`timescale 1ns/1ps
module prx_shifter #(
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sel_fall,
    input  logic              sclk_rise,
    input  logic              mosi_s,
    output logic              word_vld,
    output logic [WORD_W-1:0] word,
    output logic              frag_abort,
    output logic              miso
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] echo_q;
    logic [WORD_W-1:0] shifted;

    assign shifted = {shreg[WORD_W-2:0], mosi_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            echo_q   <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= shifted;
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt  <= '0;
                    word_vld <= 1'b1;
                    echo_q   <= shifted;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) miso <= 1'b0;
        else if (!sel) miso <= 1'b0;
        else miso <= echo_q[LAST_BIT - bit_cnt];
    end

    assign word       = echo_q;
    assign frag_abort = sel_fall && (bit_cnt != '0);

    // R2: the bit position restarts whenever the slave is deselected
    a_r2_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (bit_cnt == '0));
    // R1: a word completes only after the last bit position
    a_r1_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> ($past(bit_cnt) == LAST_BIT));
    // R8: echo line stays low while deselected
    a_r8_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !miso);
endmodule

// File: rtl/prx_pair_fsm.sv
`timescale 1ns/1ps
module prx_pair_fsm
    import prx_pkg::*;
#(
    parameter int                WORD_W   = 16,
    parameter logic [WORD_W-1:0] END_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    input  logic              frag_abort,
    input  logic              sel_fall,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              seq_done,
    output logic              link_err
);
    pair_state_t       state, nxt;
    logic [WORD_W-1:0] addr_q;
    logic              abort;
    logic              is_end;

    assign is_end = (word == END_CODE);
    assign abort  = frag_abort || (sel_fall && (state == PS_DATA));

    always_comb begin
        nxt = state;
        unique case (state)
            PS_ADDR: if (word_vld && !is_end) nxt = PS_DATA;
            PS_DATA: if (word_vld) nxt = PS_ADDR;
            default: nxt = PS_ADDR;
        endcase
        if (abort) nxt = PS_ADDR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_ADDR;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            seq_done <= 1'b0;
            link_err <= 1'b0;
            addr_q   <= '0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en    <= 1'b0;
            seq_done <= 1'b0;
            if (word_vld) begin
                unique case (state)
                    PS_ADDR: begin
                        if (is_end) begin
                            seq_done <= 1'b1;
                            link_err <= 1'b0;
                        end else begin
                            addr_q <= word;
                        end
                    end
                    PS_DATA: begin
                        wr_en   <= 1'b1;
                        wr_addr <= addr_q;
                        wr_data <= word;
                    end
                    default: ;
                endcase
            end
            if (abort) link_err <= 1'b1;
        end
    end

    // R3: write strobe lasts one cycle
    a_r3_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // R4: completion never coincides with a write
    a_r4_done_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !wr_en);
    // R4: completion pulse lasts one cycle
    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);
    // R6: an abort returns the decoder to the address slot and flags it
    a_r6_abort_recovers: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> ((state == PS_ADDR) && link_err));
    // R7: completion clears the error flag
    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !link_err);
endmodule

// File: rtl/spi_param_rx.sv
`timescale 1ns/1ps
module spi_param_rx #(
    parameter int                WORD_W      = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] END_CODE    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              seq_done,
    output logic              link_err
);
    logic [2:0]        pins_s;
    logic              cs_n_s, sclk_s, mosi_s;
    logic              sclk_d, sel_d;
    logic              sel, sel_fall, sclk_rise;
    logic              word_vld, frag_abort;
    logic [WORD_W-1:0] word;

    prx_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sclk, spi_mosi}),
        .q     (pins_s)
    );

    assign {cs_n_s, sclk_s, mosi_s} = pins_s;
    assign sel = !cs_n_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sel_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            sel_d  <= sel;
        end
    end

    assign sclk_rise = sclk_s && !sclk_d;
    assign sel_fall  = sel_d && !sel;

    prx_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .sel_fall   (sel_fall),
        .sclk_rise  (sclk_rise),
        .mosi_s     (mosi_s),
        .word_vld   (word_vld),
        .word       (word),
        .frag_abort (frag_abort),
        .miso       (spi_miso)
    );

    prx_pair_fsm #(
        .WORD_W   (WORD_W),
        .END_CODE (END_CODE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_vld   (word_vld),
        .word       (word),
        .frag_abort (frag_abort),
        .sel_fall   (sel_fall),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .seq_done   (seq_done),
        .link_err   (link_err)
    );
endmodule

// File: tb/spi_param_rx_tb.sv
`timescale 1ns/1ps
module spi_param_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        wr_en;
    logic [15:0] wr_addr, wr_data;
    logic        seq_done, link_err;

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, done_cnt = 0, width_viol = 0;
    logic [15:0] last_a = '0, last_d = '0;
    logic        wr_prev = 1'b0, done_prev = 1'b0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    spi_param_rx u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .seq_done(seq_done),
        .link_err(link_err)
    );

    // event monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (wr_en) begin
            wr_cnt <= wr_cnt + 1;
            last_a <= wr_addr;
            last_d <= wr_data;
        end
        if (seq_done) done_cnt <= done_cnt + 1;
        if ((wr_en && wr_prev) || (seq_done && done_prev)) width_viol <= width_viol + 1;
        wr_prev   <= wr_en;
        done_prev <= seq_done;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sel_on();
        spi_cs_n = 1'b0;
        #200;
    endtask

    task automatic sel_off();
        #100;
        spi_cs_n = 1'b1;
        #300;
    endtask

    task automatic xfer(input logic [15:0] tx, output logic [15:0] rx, input int nbits = 16);
        rx = '0;
        for (int k = 0; k < nbits; k++) begin
            spi_mosi = tx[15-k];
            #100;
            spi_sclk = 1'b1;
            rx[15-k] = spi_miso;
            #100;
            spi_sclk = 1'b0;
        end
    endtask

    task automatic t_reset();
        #103;
        check(!wr_en, "R9 wr_en low", 32'(wr_en), 0);
        check(!seq_done, "R9 seq_done low", 32'(seq_done), 0);
        check(!link_err, "R9 link_err low", 32'(link_err), 0);
        check(!spi_miso, "R9 miso low", 32'(spi_miso), 0);
    endtask

    // echo of previous word, end code closing, first echo is zero
    task automatic t_echo();
        logic [15:0] r0, r1, r2;
        int w0, d0;
        w0 = wr_cnt; d0 = done_cnt;
        sel_on();
        xfer(16'hA5C3, r0);
        xfer(16'h3C96, r1);
        xfer(16'hFFFF, r2);
        check(spi_miso == 1'b1, "R8 miso during select", 32'(spi_miso), 1);
        sel_off();
        check(r0 == 16'h0000, "R8 first echo zero", 32'(r0), 0);
        check(r1 == 16'hA5C3, "R8 echo word1", 32'(r1), 32'hA5C3);
        check(r2 == 16'h3C96, "R8 echo word2", 32'(r2), 32'h3C96);
        check(!spi_miso, "R8 miso low deselected", 32'(spi_miso), 0);
        check(wr_cnt == w0 + 1, "R3 one write", 32'(wr_cnt - w0), 1);
        check(last_a == 16'hA5C3 && last_d == 16'h3C96, "R1 R3 pair content",
              {last_a, last_d}, 32'hA5C33C96);
        check(done_cnt == d0 + 1, "R4 done pulse", 32'(done_cnt - d0), 1);
    endtask

    task automatic t_multi();
        logic [15:0] r;
        int w0, d0;
        w0 = wr_cnt; d0 = done_cnt;
        sel_on();
        xfer(16'h0011, r);
        xfer(16'h8001, r);
        check(wr_cnt == w0 + 1 && last_a == 16'h0011 && last_d == 16'h8001,
              "R3 first pair", {last_a, last_d}, 32'h00118001);
        xfer(16'h0022, r);
        xfer(16'h7FFE, r);
        xfer(16'hFFFF, r);
        sel_off();
        check(wr_cnt == w0 + 2, "R3 two writes", 32'(wr_cnt - w0), 2);
        check(last_a == 16'h0022 && last_d == 16'h7FFE, "R3 second pair",
              {last_a, last_d}, 32'h00227FFE);
        check(done_cnt == d0 + 1, "R4 one done", 32'(done_cnt - d0), 1);
    endtask

    task automatic t_end_in_data();
        logic [15:0] r;
        int w0, d0;
        w0 = wr_cnt; d0 = done_cnt;
        sel_on();
        xfer(16'h0010, r);
        xfer(16'hFFFF, r);
        sel_off();
        check(wr_cnt == w0 + 1, "R4 end code as data writes", 32'(wr_cnt - w0), 1);
        check(last_a == 16'h0010 && last_d == 16'hFFFF, "R4 end code data value",
              {last_a, last_d}, 32'h0010FFFF);
        check(done_cnt == d0, "R4 no done in data slot", 32'(done_cnt - d0), 0);
    endtask

    task automatic t_deselected();
        logic [15:0] r;
        int w0;
        w0 = wr_cnt;
        spi_mosi = 1'b1;
        for (int k = 0; k < 10; k++) begin
            #100 spi_sclk = 1'b1;
            #100 spi_sclk = 1'b0;
        end
        #200;
        check(wr_cnt == w0, "R2 no write while deselected", 32'(wr_cnt - w0), 0);
        check(!spi_miso, "R2 miso low while deselected", 32'(spi_miso), 0);
        sel_on();
        xfer(16'h0042, r);
        xfer(16'h0007, r);
        sel_off();
        check(wr_cnt == w0 + 1 && last_a == 16'h0042 && last_d == 16'h0007,
              "R2 alignment after deselected clocks", {last_a, last_d}, 32'h00420007);
    endtask

    task automatic t_abort_frame();
        logic [15:0] r;
        int w0, d0;
        w0 = wr_cnt; d0 = done_cnt;
        sel_on();
        xfer(16'hFFFF, r, 7);
        sel_off();
        check(link_err == 1'b1, "R5 err after partial word", 32'(link_err), 1);
        check(wr_cnt == w0 && done_cnt == d0, "R5 partial discarded",
              32'(wr_cnt - w0 + done_cnt - d0), 0);
        sel_on();
        xfer(16'h0200, r);
        xfer(16'h0300, r);
        check(link_err == 1'b1, "R7 err held across write", 32'(link_err), 1);
        xfer(16'hFFFF, r);
        sel_off();
        check(last_a == 16'h0200 && last_d == 16'h0300, "R5 fresh word after abort",
              {last_a, last_d}, 32'h02000300);
        check(!link_err, "R7 err cleared by done", 32'(link_err), 0);
    endtask

    task automatic t_abort_pair();
        logic [15:0] r;
        int w0;
        w0 = wr_cnt;
        sel_on();
        xfer(16'h0400, r);
        sel_off();
        check(link_err == 1'b1, "R6 err after lone address", 32'(link_err), 1);
        check(wr_cnt == w0, "R6 no write from lone address", 32'(wr_cnt - w0), 0);
        sel_on();
        xfer(16'h0500, r);
        xfer(16'h0600, r);
        sel_off();
        check(wr_cnt == w0 + 1 && last_a == 16'h0500 && last_d == 16'h0600,
              "R6 next word is address", {last_a, last_d}, 32'h05000600);
        sel_on();
        xfer(16'hFFFF, r);
        sel_off();
        check(!link_err, "R7 err cleared", 32'(link_err), 0);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #51;
        rst_n = 1'b1;
        t_reset();
        t_echo();
        t_multi();
        t_end_in_data();
        t_deselected();
        t_abort_frame();
        t_abort_pair();
        check(width_viol == 0, "R3 R4 single-cycle pulses", 32'(width_viol), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule